// File: doc/BRIEF.md
# Machine-Cycle Bus and DMA Sequencer

This block paces the memory side of a small 8-bit processor core. Every machine cycle is a fixed run of clock periods. During each cycle the block puts a wide address onto a narrow multiplexed bus, most significant byte first. It marks the first beat with an address strobe and raises memory read or write strobes in fixed windows. It also reports on a 2-bit code what kind of cycle is running. Instruction decode and arithmetic belong to the surrounding core. The core supplies the address for fetch and execute cycles and says, at the end of each fetch, whether the instruction needs a second execute cycle.

Direct memory transfers go in the gaps between instructions. A transfer into memory or out of memory takes one machine cycle. Its address comes from a pointer register in the register file, and the block asks for that pointer to be bumped after each transfer. With the clear and wait controls both held active, the core stops fetching, and inbound transfers alone fill memory at successive addresses, so a program can be loaded with no bootstrap code. All state is held in plain flip-flops. A slow or stopped clock therefore loses nothing, and wait alone freezes the sequencer.

Top module: `mc_bus_sequencer`

## Requirements
- R1: A machine cycle lasts exactly CLKS_PER_MC clock periods (default 8). The address strobe is high in the first clock period of each cycle (phase 0) and low in all other periods.
- R2: The bus output carries the high byte of the cycle's address in phase 0 and the low byte in phases 1 to 7. The address is taken from the core's address input in fetch, execute and idle cycles, and from the DMA pointer input in DMA cycles.
- R3: Each instruction is one fetch cycle followed by one execute cycle. If the long-instruction input is high in the last clock of the fetch cycle, a second execute cycle follows.
- R4: At the last clock of an instruction's final cycle, and at the last clock of a DMA or idle cycle, the requests are sampled. An inbound request starts a DMA-in cycle. Otherwise an outbound request starts a DMA-out cycle. Otherwise a fetch follows. Inbound wins when both requests are present.
- R5: The pointer-increment output pulses for one clock, in phase 7 of every DMA cycle, and never at any other time.
- R6: Memory read is high in phases 3 to 7 of fetch and DMA-out cycles and low at all other times.
- R7: Memory write is high in phases 5 and 6 of DMA-in cycles and low at all other times.
- R8: The cycle code is 00 for fetch, 01 for execute and idle cycles, and 10 for DMA. The value 11 is reserved for interrupt cycles and is never driven. The code is constant for the whole machine cycle.
- R9: While clear and wait are both high (load mode), no fetch or execute cycle starts. At the end of each cycle an inbound request gives a DMA-in cycle and anything else gives an idle cycle. The outbound request is ignored.
- R10: While wait is high and clear is low, the phase, the cycle kind and every output stay frozen, and no pointer increment is issued.
- R11: While clear is high and wait is low, the block holds phase 0 in an idle cycle, with code 01 and no read or write strobe. After clear falls, one idle cycle runs, DMA requests are sampled at its end, and then the first fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; any rate down to stopped |
| clear_i | input | 1 | Clear control, active high |
| wait_i | input | 1 | Wait control, active high |
| dma_in_req_i | input | 1 | Request for a transfer into memory |
| dma_out_req_i | input | 1 | Request for a transfer out of memory |
| instr_long_i | input | 1 | From decode: instruction needs two execute cycles |
| addr_i | input | ADDR_W | Address for fetch, execute and idle cycles |
| dma_ptr_i | input | ADDR_W | DMA pointer register value |
| bus_addr_o | output | BUS_W | Multiplexed address byte |
| addr_stb_o | output | 1 | High during the high-byte beat |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| cyc_code_o | output | 2 | Machine-cycle kind code |
| ptr_inc_o | output | 1 | Request to increment the DMA pointer |

## Verification
The bench builds the block with its defaults: a 16-bit address on an 8-bit bus, eight clocks per machine cycle, and inbound transfers placed ahead of outbound ones. With only two address beats, the stretch of phases 1 to 7 that holds the low byte is long, and both strobe windows sit well inside one cycle. A mismatched window edge or a beat that lands one phase late therefore shows up on every cycle the reference model predicts. The eight-phase cycle also lets the bench raise wait at arbitrary phases, including phase 7 of a DMA cycle where an increment would otherwise be issued. It can enter and leave load mode with requests in both directions pending.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [2:0] {
      SL_IDLE,
      SL_FETCH,
      SL_EXEC1,
      SL_EXEC2,
      SL_DMA_IN,
      SL_DMA_OUT
   } slot_t;

   typedef enum logic [1:0] {
      CY_FETCH = 2'b00,
      CY_EXEC  = 2'b01,
      CY_DMA   = 2'b10,
      CY_INTR  = 2'b11
   } cyc_code_t;

   function automatic cyc_code_t slot_code(slot_t s);
      case (s)
         SL_FETCH:             return CY_FETCH;
         SL_DMA_IN, SL_DMA_OUT: return CY_DMA;
         default:              return CY_EXEC;
      endcase
   endfunction

endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
   parameter int CLKS_PER_MC = 8,
   localparam int PH_W = $clog2(CLKS_PER_MC)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   output logic [PH_W-1:0] ph,
   output logic            last
);

   if (CLKS_PER_MC < 2) begin : g_bad_len
      $error("machine cycle needs at least two clocks");
   end

   assign last = (ph == PH_W'(CLKS_PER_MC - 1));

   always_ff @(posedge clk) begin
      if (rst)
         ph <= '0;
      else if (adv)
         ph <= last ? '0 : ph + 1'b1;
   end

   assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
      (adv && !last) |=> (ph == $past(ph) + 1'b1));

   assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (adv && last) |=> (ph == '0));

   assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(ph));

endmodule

// File: rtl/mcs_slot_sched.sv
module mcs_slot_sched
   import mcs_pkg::*;
#(
   parameter bit IN_OVER_OUT = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  adv,
   input  logic  load,
   input  logic  last,
   input  logic  din,
   input  logic  dout,
   input  logic  long_i,
   output slot_t slot
);

   slot_t pick;
   logic  long_q;

   if (IN_OVER_OUT) begin : g_in_first
      always_comb begin
         if (din)       pick = SL_DMA_IN;
         else if (dout) pick = SL_DMA_OUT;
         else           pick = SL_FETCH;
      end
   end else begin : g_out_first
      always_comb begin
         if (dout)      pick = SL_DMA_OUT;
         else if (din)  pick = SL_DMA_IN;
         else           pick = SL_FETCH;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         slot   <= SL_IDLE;
         long_q <= 1'b0;
      end else if (adv && last) begin
         if (load) begin
            slot <= din ? SL_DMA_IN : SL_IDLE;
         end else begin
            case (slot)
               SL_FETCH: begin
                  slot   <= SL_EXEC1;
                  long_q <= long_i;
               end
               SL_EXEC1: slot <= long_q ? SL_EXEC2 : pick;
               default:  slot <= pick;
            endcase
         end
      end
   end

   assert_slot_steady_R8: assert property (@(posedge clk) disable iff (rst)
      (adv && !last) |=> $stable(slot));

   if (IN_OVER_OUT) begin : g_prio_chk
      assert_in_beats_out_R4: assert property (@(posedge clk) disable iff (rst)
         (slot == SL_DMA_OUT && $past(last) && $past(adv)) |-> !$past(din));
   end

   assert_load_no_fetch_R9: assert property (@(posedge clk) disable iff (rst)
      (adv && last && load) |=> (slot == SL_DMA_IN || slot == SL_IDLE));

   assert_fetch_then_exec_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && last && !load && slot == SL_FETCH) |=> (slot == SL_EXEC1));

endmodule

// File: rtl/mcs_bus_drive.sv
module mcs_bus_drive
   import mcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BUS_W       = 8,
   parameter int CLKS_PER_MC = 8,
   parameter int RD_FIRST    = 3,
   parameter int RD_LAST     = 7,
   parameter int WR_FIRST    = 5,
   parameter int WR_LAST     = 6,
   localparam int PH_W       = $clog2(CLKS_PER_MC),
   localparam int NBEAT      = ADDR_W / BUS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              last,
   input  slot_t             slot,
   input  logic [PH_W-1:0]   ph,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] ptr_i,
   output logic [BUS_W-1:0]  bus_o,
   output logic              stb_o,
   output logic              rd_o,
   output logic              wr_o,
   output cyc_code_t         code_o,
   output logic              inc_o
);

   if (ADDR_W % BUS_W != 0) begin : g_bad_split
      $error("address width must be a multiple of bus width");
   end
   if (NBEAT > CLKS_PER_MC) begin : g_bad_beats
      $error("more address beats than clocks per cycle");
   end
   if (RD_FIRST > RD_LAST || RD_LAST >= CLKS_PER_MC) begin : g_bad_rd
      $error("read window outside the machine cycle");
   end
   if (WR_FIRST > WR_LAST || WR_LAST >= CLKS_PER_MC) begin : g_bad_wr
      $error("write window outside the machine cycle");
   end

   logic [CLKS_PER_MC-1:0] rd_mask;
   logic [CLKS_PER_MC-1:0] wr_mask;
   logic [BUS_W-1:0]       beat [NBEAT];
   logic [ADDR_W-1:0]      src;
   logic                   is_dma;

   for (genvar p = 0; p < CLKS_PER_MC; p++) begin : g_win
      assign rd_mask[p] = (p >= RD_FIRST) && (p <= RD_LAST);
      assign wr_mask[p] = (p >= WR_FIRST) && (p <= WR_LAST);
   end

   assign is_dma = (slot == SL_DMA_IN) || (slot == SL_DMA_OUT);
   assign src    = is_dma ? ptr_i : addr_i;

   for (genvar b = 0; b < NBEAT; b++) begin : g_beat
      assign beat[b] = src[ADDR_W-1-b*BUS_W -: BUS_W];
   end

   always_comb begin
      bus_o = beat[NBEAT-1];
      for (int b = 0; b < NBEAT; b++) begin
         if (ph == PH_W'(b)) bus_o = beat[b];
      end
   end

   assign stb_o  = (ph == '0);
   assign rd_o   = ((slot == SL_FETCH) || (slot == SL_DMA_OUT)) && rd_mask[ph];
   assign wr_o   = (slot == SL_DMA_IN) && wr_mask[ph];
   assign code_o = slot_code(slot);
   assign inc_o  = is_dma && last && adv;

   assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(rd_o && wr_o));

   assert_wr_in_dma_R7: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> (code_o == CY_DMA));

   assert_inc_in_dma_R5: assert property (@(posedge clk) disable iff (rst)
      inc_o |-> (code_o == CY_DMA && !stb_o));

   assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
      code_o != CY_INTR);

   assert_no_inc_halt_R10: assert property (@(posedge clk) disable iff (rst)
      !adv |-> !inc_o);

endmodule

// File: rtl/mc_bus_sequencer.sv
module mc_bus_sequencer
   import mcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BUS_W       = 8,
   parameter int CLKS_PER_MC = 8,
   parameter int RD_FIRST    = 3,
   parameter int RD_LAST     = 7,
   parameter int WR_FIRST    = 5,
   parameter int WR_LAST     = 6,
   parameter bit IN_OVER_OUT = 1'b1,
   localparam int PH_W       = $clog2(CLKS_PER_MC)
) (
   input  logic              clk,
   input  logic              clear_i,
   input  logic              wait_i,
   input  logic              dma_in_req_i,
   input  logic              dma_out_req_i,
   input  logic              instr_long_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] dma_ptr_i,
   output logic [BUS_W-1:0]  bus_addr_o,
   output logic              addr_stb_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [1:0]        cyc_code_o,
   output logic              ptr_inc_o
);

   logic            rst;
   logic            load;
   logic            adv;
   logic            last;
   logic [PH_W-1:0] ph;
   slot_t           slot;
   cyc_code_t       code;

   assign rst  = clear_i && !wait_i;
   assign load = clear_i && wait_i;
   assign adv  = !(clear_i ^ wait_i);

   mcs_phase_ctr #(
      .CLKS_PER_MC(CLKS_PER_MC)
   ) u_phase (
      .clk (clk),
      .rst (rst),
      .adv (adv),
      .ph  (ph),
      .last(last)
   );

   mcs_slot_sched #(
      .IN_OVER_OUT(IN_OVER_OUT)
   ) u_sched (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .load  (load),
      .last  (last),
      .din   (dma_in_req_i),
      .dout  (dma_out_req_i),
      .long_i(instr_long_i),
      .slot  (slot)
   );

   mcs_bus_drive #(
      .ADDR_W     (ADDR_W),
      .BUS_W      (BUS_W),
      .CLKS_PER_MC(CLKS_PER_MC),
      .RD_FIRST   (RD_FIRST),
      .RD_LAST    (RD_LAST),
      .WR_FIRST   (WR_FIRST),
      .WR_LAST    (WR_LAST)
   ) u_drive (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .last  (last),
      .slot  (slot),
      .ph    (ph),
      .addr_i(addr_i),
      .ptr_i (dma_ptr_i),
      .bus_o (bus_addr_o),
      .stb_o (addr_stb_o),
      .rd_o  (mem_rd_o),
      .wr_o  (mem_wr_o),
      .code_o(code),
      .inc_o (ptr_inc_o)
   );

   assign cyc_code_o = code;

   assert_stb_once_R1: assert property (@(posedge clk) disable iff (rst)
      (adv && addr_stb_o) |=> !addr_stb_o);

   assert_reset_quiet_R11: assert property (@(posedge clk)
      rst |=> (rst -> (!mem_rd_o && !mem_wr_o && cyc_code_o == 2'b01)));

endmodule

// File: tb/tb_mc_bus_sequencer.sv
`timescale 1ns/100ps
module tb_mc_bus_sequencer;

   localparam int K_IDLE = 0, K_FETCH = 1, K_EX1 = 2, K_EX2 = 3, K_DIN = 4, K_DOUT = 5;

   logic        clk = 1'b0;
   logic        clear_i = 1'b1;
   logic        wait_i = 1'b0;
   logic        dma_in_req_i = 1'b0;
   logic        dma_out_req_i = 1'b0;
   logic        instr_long_i = 1'b0;
   logic [15:0] addr_i = 16'h0000;
   logic [15:0] r0 = 16'h0200;
   logic [7:0]  bus_addr_o;
   logic        addr_stb_o, mem_rd_o, mem_wr_o, ptr_inc_o;
   logic [1:0]  cyc_code_o;

   int vectors = 0;
   int fails = 0;
   bit started = 0;
   bit finished = 0;

   int mph = 0;
   int mk = K_IDLE;
   bit mlong = 0;

   bit win_both = 0, win_load = 0, win_out = 0;
   int both_dout_rd = 0, out_rd = 0, load_rd = 0, load_wr = 0;

   always #2 clk = ~clk;

   mc_bus_sequencer dut (
      .clk          (clk),
      .clear_i      (clear_i),
      .wait_i       (wait_i),
      .dma_in_req_i (dma_in_req_i),
      .dma_out_req_i(dma_out_req_i),
      .instr_long_i (instr_long_i),
      .addr_i       (addr_i),
      .dma_ptr_i    (r0),
      .bus_addr_o   (bus_addr_o),
      .addr_stb_o   (addr_stb_o),
      .mem_rd_o     (mem_rd_o),
      .mem_wr_o     (mem_wr_o),
      .cyc_code_o   (cyc_code_o),
      .ptr_inc_o    (ptr_inc_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int next_pick();
      if (dma_in_req_i) return K_DIN;
      if (dma_out_req_i) return K_DOUT;
      return K_FETCH;
   endfunction

   function automatic bit m_dma();
      return (mk == K_DIN) || (mk == K_DOUT);
   endfunction

   function automatic bit m_inc();
      return m_dma() && (mph == 7) && !(clear_i ^ wait_i);
   endfunction

   // reference model update
   always @(posedge clk) begin
      started <= 1'b1;
      if (m_inc()) r0 <= r0 + 16'd1;
      if (clear_i && !wait_i) begin
         mph = 0; mk = K_IDLE; mlong = 0;
      end else if (!clear_i && wait_i) begin
         mph = mph;
      end else if (mph == 7) begin
         mph = 0;
         if (clear_i && wait_i) mk = dma_in_req_i ? K_DIN : K_IDLE;
         else if (mk == K_FETCH) begin mk = K_EX1; mlong = instr_long_i; end
         else if (mk == K_EX1 && mlong) mk = K_EX2;
         else mk = next_pick();
      end else begin
         mph = mph + 1;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started && !finished) begin
         logic [15:0] src;
         int ecode;
         bit erd, ewr;
         src   = m_dma() ? r0 : addr_i;
         ecode = (mk == K_FETCH) ? 0 : (m_dma() ? 2 : 1);
         erd   = ((mk == K_FETCH) || (mk == K_DOUT)) && mph >= 3 && mph <= 7;
         ewr   = (mk == K_DIN) && mph >= 5 && mph <= 6;
         check(addr_stb_o == (mph == 0), "R1 address strobe", addr_stb_o, mph == 0);
         check(bus_addr_o == ((mph == 0) ? src[15:8] : src[7:0]), "R2 bus byte",
               bus_addr_o, (mph == 0) ? src[15:8] : src[7:0]);
         check(cyc_code_o == ecode[1:0], "R3 R4 R8 cycle code", cyc_code_o, ecode);
         check(ptr_inc_o == m_inc(), "R5 pointer increment", ptr_inc_o, m_inc());
         check(mem_rd_o == erd, "R6 memory read", mem_rd_o, erd);
         check(mem_wr_o == ewr, "R7 memory write", mem_wr_o, ewr);
         if (win_both && mem_rd_o && cyc_code_o == 2'b10) both_dout_rd++;
         if (win_out && mem_rd_o && cyc_code_o == 2'b10) out_rd++;
         if (win_load && mem_rd_o) load_rd++;
         if (win_load && mem_wr_o) load_wr++;
      end
   end

   task automatic step(input int n, input bit rnd_long);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         addr_i = 16'($urandom);
         if (rnd_long) instr_long_i = 1'($urandom);
      end
   endtask

   initial begin
      int r0_start;
      logic [7:0] s_bus;
      logic [1:0] s_code;
      logic s_stb, s_rd, s_wr;

      // R11: held clear
      step(6, 1'b0);
      @(negedge clk);
      check(cyc_code_o == 2'b01 && !mem_rd_o && !mem_wr_o && addr_stb_o,
            "R11 reset state", {cyc_code_o, mem_rd_o, mem_wr_o, addr_stb_o}, 5'b01001);
      #1 clear_i = 1'b0;
      step(8, 1'b0);
      @(negedge clk);
      check(cyc_code_o == 2'b00, "R11 first fetch after idle cycle", cyc_code_o, 0);
      step(200, 1'b1);

      // R4: inbound, outbound, then both
      dma_in_req_i = 1'b1;
      step(40, 1'b1);
      dma_in_req_i = 1'b0; dma_out_req_i = 1'b1; win_out = 1;
      step(40, 1'b1);
      win_out = 0;
      check(out_rd > 0, "R4 outbound-only gives DMA reads", out_rd, 1);
      dma_in_req_i = 1'b1; step(9, 1'b1); win_both = 1;
      step(60, 1'b1);
      win_both = 0;
      check(both_dout_rd == 0, "R4 inbound beats outbound", both_dout_rd, 0);
      dma_out_req_i = 1'b0;
      step(13, 1'b1);

      // R10: wait alone freezes, with an inbound request pending
      wait_i = 1'b1;
      r0_start = r0;
      @(negedge clk);
      s_bus = bus_addr_o; s_code = cyc_code_o; s_stb = addr_stb_o;
      s_rd = mem_rd_o; s_wr = mem_wr_o;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         check(bus_addr_o == s_bus && cyc_code_o == s_code && addr_stb_o == s_stb &&
               mem_rd_o == s_rd && mem_wr_o == s_wr && !ptr_inc_o,
               "R10 frozen outputs", {bus_addr_o, cyc_code_o, ptr_inc_o},
               {s_bus, s_code, 1'b0});
      end
      check(r0 == r0_start, "R10 no increment while halted", r0, r0_start);
      #1 wait_i = 1'b0;
      step(50, 1'b1);
      dma_in_req_i = 1'b0;
      step(30, 1'b1);

      // R9: load mode with both requests
      clear_i = 1'b1;
      step(3, 1'b0);
      wait_i = 1'b1; dma_out_req_i = 1'b1; win_load = 1;
      step(24, 1'b0);
      r0_start = r0;
      dma_in_req_i = 1'b1;
      step(80, 1'b0);
      dma_in_req_i = 1'b0;
      step(16, 1'b0);
      win_load = 0;
      check(load_rd == 0, "R9 no reads in load mode", load_rd, 0);
      check(load_wr == 2 * (r0 - r0_start) && load_wr > 0,
            "R9 R7 writes match pointer advance", load_wr, 2 * (r0 - r0_start));
      dma_out_req_i = 1'b0; wait_i = 1'b0;
      step(3, 1'b0);
      clear_i = 1'b0;
      step(120, 1'b1);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule